// File: doc/BRIEF.md
# Master-Clocked Stereo PCM Serial Port

This block moves stereo PCM samples between a processor core and a three-wire serial audio link while acting as the only clock source on that link. It derives a bit clock from the system clock through a programmable divider. It also derives a left/right frame clock from the bit clock. In each frame it shifts one left/right pair out and captures one left/right pair in, so both directions run at the same time and at the same sample rate.

Two framing modes are selected by one input. The first is I2S with 18-bit samples in a 64-bit-clock frame. The second is left-justified with 20-bit samples in a 128-bit-clock frame. The parallel side always uses 20-bit words aligned to the MSB. A single-cycle `frame_done` strobe marks each frame boundary. At that strobe the received pair is published and the next transmit pair is taken from a one-deep holding buffer. The core fills that buffer with `tx_load`. If the core has not refilled it, the previous pair is sent again.

Top module: `pcm_master_port`

## Requirements
- R1: `bclk` is always driven by the block; each half period lasts `half_div`+1 system clock cycles.
- R2: A frame lasts 64 bit clocks when `lj_mode`=0 (I2S) and 128 when `lj_mode`=1 (left-justified). `frame_done` is high for one system cycle, in the same cycle that `bclk` falls to begin a new frame.
- R3: `lrclk` and `sdo` change state only in the cycle in which `bclk` falls.
- R4: `sdi` is captured only at the rising edges of `bclk`.
- R5: In I2S mode each slot carries bits [19:2] of the 20-bit word, MSB first. The MSB goes on the second bit clock of the slot, one bit clock after the `lrclk` edge. The left slot has `lrclk`=0. Word bits [1:0] are never sent, and they read back as 0 on receive.
- R6: In left-justified mode each slot carries all 20 bits, MSB first. The MSB goes on the first bit clock of the slot. The left slot has `lrclk`=1.
- R7: Each frame is split into two equal slots, left first and then right, so `lrclk` holds each level for half a frame.
- R8: Bit clocks of a slot that follow the LSB drive `sdo`=0, and the value on `sdi` during them has no effect on the received words.
- R9: At `frame_done`, `rx_left`/`rx_right` show the pair received in the frame that just ended. A pair loaded with `tx_load` during a frame is sent in the next frame. If no pair was loaded, the last pair sent is sent again.
- R10: A change on `lj_mode` takes effect only at the next frame boundary; the frame in progress keeps its format and length.
- R11: After reset the block is in these states. `bclk`=0, `frame_done`=0 and `sdo`=0. `lrclk` is at the left level of the selected mode. Both received words are 0. The first frame transmits zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lj_mode | input | 1 | Framing select: 0 I2S, 1 left-justified |
| half_div | input | DIV_W | Bit-clock half period minus one, in system cycles |
| tx_left | input | 20 | Left word to transmit, MSB aligned |
| tx_right | input | 20 | Right word to transmit, MSB aligned |
| tx_load | input | 1 | Stores tx_left/tx_right for the next frame |
| rx_left | output | 20 | Last received left word, MSB aligned |
| rx_right | output | 20 | Last received right word, MSB aligned |
| frame_done | output | 1 | One-cycle frame boundary strobe |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Left/right frame clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with the default `DIV_W`=8 and runs `half_div`=1, which gives a four-cycle bit clock. With that setting, frames of both formats are short enough to run back to back. The bench switches modes mid-frame in both directions, including the I2S-to-left-justified boundary, where `lrclk` does not toggle. The receive side is looped back from `sdo`, and the bench forces ones onto `sdi` outside the sample bits, which exercises the tail-ignore rule on every frame. Frames without a load exercise the repeat path.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int WORD_W    = 20;
    localparam int I2S_W     = 18;
    localparam int LJ_W      = 20;
    localparam int I2S_FRAME = 64;
    localparam int LJ_FRAME  = 128;
    localparam int IDX_W     = $clog2(LJ_FRAME);
    localparam int POS_W     = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;

    typedef struct packed {
        logic             ch;      // 0 left, 1 right
        logic             active;  // carries a sample bit
        logic [POS_W-1:0] pos;     // bit index into the parallel word
        logic             lr;      // frame clock level
    } slot_t;

    function automatic logic [IDX_W-1:0] frame_last(fmt_e fmt);
        return (fmt == FMT_LJ) ? IDX_W'(LJ_FRAME - 1) : IDX_W'(I2S_FRAME - 1);
    endfunction

    function automatic slot_t slot_decode(logic [IDX_W-1:0] idx, fmt_e fmt);
        slot_t s;
        int    half;
        int    p;
        half = (fmt == FMT_LJ) ? LJ_FRAME / 2 : I2S_FRAME / 2;
        s.ch = (int'(idx) >= half);
        p    = int'(idx) - (s.ch ? half : 0);
        if (fmt == FMT_LJ) begin
            s.active = (p < LJ_W);
            s.pos    = POS_W'(WORD_W - 1 - p);
            s.lr     = ~s.ch;
        end else begin
            s.active = (p >= 1) && (p <= I2S_W);
            s.pos    = POS_W'(WORD_W - p);
            s.lr     = s.ch;
        end
        return s;
    endfunction

endpackage

// File: rtl/pcm_bitclock.sv
module pcm_bitclock
    import pcm_port_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt_req,
    input  logic [DIV_W-1:0] half_div,
    output logic             bclk,
    output logic [IDX_W-1:0] bit_idx,
    output fmt_e             fmt_q,
    output logic             rise_tick,
    output logic             frame_tick,
    output logic             frame_done
);

    logic [DIV_W-1:0] cnt;
    logic             tick;
    logic             fall_tick;

    assign tick       = (cnt >= half_div);
    assign rise_tick  = tick && !bclk;
    assign fall_tick  = tick && bclk;
    assign frame_tick = fall_tick && (bit_idx == frame_last(fmt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            bclk       <= 1'b0;
            bit_idx    <= '0;
            fmt_q      <= fmt_req;
            frame_done <= 1'b0;
        end else begin
            frame_done <= frame_tick;
            if (tick) begin
                cnt  <= '0;
                bclk <= ~bclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (fall_tick) begin
                bit_idx <= frame_tick ? '0 : bit_idx + 1'b1;
                if (frame_tick) fmt_q <= fmt_req;
            end
        end
    end

    logic chk_ok;
    always_ff @(posedge clk) chk_ok <= !rst;

    // R2: a boundary follows the last bit of the format in force
    a_r2_frame_len: assert property (@(posedge clk) disable iff (rst || !chk_ok)
        frame_done |-> ($fell(bclk) && $past(bit_idx) == frame_last($past(fmt_q))));

    // R10: the format register moves only at a boundary
    a_r10_mode_at_boundary: assert property (@(posedge clk) disable iff (rst || !chk_ok)
        !$stable(fmt_q) |-> frame_done);

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
    import pcm_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t tx_left,
    input  word_t tx_right,
    input  logic  tx_load,
    input  logic  frame_tick,
    input  logic  frame_done,
    input  slot_t slot,
    output logic  sdo
);

    word_t hold [2];
    word_t pend [2];
    logic  pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold[0] <= '0;
            hold[1] <= '0;
            pend[0] <= '0;
            pend[1] <= '0;
            pend_v  <= 1'b0;
        end else begin
            if (frame_tick && pend_v) begin
                hold[0] <= pend[0];
                hold[1] <= pend[1];
                pend_v  <= 1'b0;
            end
            if (tx_load) begin
                pend[0] <= tx_left;
                pend[1] <= tx_right;
                pend_v  <= 1'b1;
            end
        end
    end

    word_t cur_word;
    assign cur_word = hold[slot.ch];
    assign sdo      = slot.active ? cur_word[slot.pos] : 1'b0;

    logic chk_ok;
    always_ff @(posedge clk) chk_ok <= !rst;

    // R9: the transmit pair is replaced only at a boundary
    a_r9_hold_at_boundary: assert property (@(posedge clk) disable iff (rst || !chk_ok)
        (!$stable(hold[0]) || !$stable(hold[1])) |-> frame_done);

    // R9: with nothing pending the previous pair is repeated
    a_r9_repeat: assert property (@(posedge clk) disable iff (rst || !chk_ok)
        (frame_done && !$past(pend_v)) |-> ($stable(hold[0]) && $stable(hold[1])));

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
    import pcm_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sdi,
    input  logic  bclk,
    input  logic  rise_tick,
    input  logic  frame_tick,
    input  logic  frame_done,
    input  slot_t slot,
    output word_t rx_word [2]
);

    word_t acc [2];
    logic  chk_ok;
    always_ff @(posedge clk) chk_ok <= !rst;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                acc[c]     <= '0;
                rx_word[c] <= '0;
            end else if (frame_tick) begin
                rx_word[c] <= acc[c];
                acc[c]     <= '0;
            end else if (rise_tick && slot.active && slot.ch == 1'(c)) begin
                acc[c][slot.pos] <= sdi;
            end
        end

        // R4: capture state moves only with a rising bit clock or a boundary clear
        a_r4_capture_on_rise: assert property (@(posedge clk) disable iff (rst || !chk_ok)
            !$stable(acc[c]) |-> ($rose(bclk) || frame_done));
    end

endmodule

// File: rtl/pcm_master_port.sv
module pcm_master_port
    import pcm_port_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lj_mode,
    input  logic [DIV_W-1:0] half_div,
    input  logic [19:0]      tx_left,
    input  logic [19:0]      tx_right,
    input  logic             tx_load,
    output logic [19:0]      rx_left,
    output logic [19:0]      rx_right,
    output logic             frame_done,
    output logic             bclk,
    output logic             lrclk,
    output logic             sdo,
    input  logic             sdi
);

    logic [IDX_W-1:0] bit_idx;
    fmt_e             fmt_q;
    logic             rise_tick;
    logic             frame_tick;
    slot_t            slot;
    word_t            rx_word [2];

    pcm_bitclock #(.DIV_W(DIV_W)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .fmt_req    (fmt_e'(lj_mode)),
        .half_div   (half_div),
        .bclk       (bclk),
        .bit_idx    (bit_idx),
        .fmt_q      (fmt_q),
        .rise_tick  (rise_tick),
        .frame_tick (frame_tick),
        .frame_done (frame_done)
    );

    assign slot  = slot_decode(bit_idx, fmt_q);
    assign lrclk = slot.lr;

    pcm_tx_path u_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_left    (tx_left),
        .tx_right   (tx_right),
        .tx_load    (tx_load),
        .frame_tick (frame_tick),
        .frame_done (frame_done),
        .slot       (slot),
        .sdo        (sdo)
    );

    pcm_rx_path u_rx (
        .clk        (clk),
        .rst        (rst),
        .sdi        (sdi),
        .bclk       (bclk),
        .rise_tick  (rise_tick),
        .frame_tick (frame_tick),
        .frame_done (frame_done),
        .slot       (slot),
        .rx_word    (rx_word)
    );

    assign rx_left  = rx_word[0];
    assign rx_right = rx_word[1];

    logic chk_ok;
    always_ff @(posedge clk) chk_ok <= !rst;

    // R3: frame clock moves only with a falling bit clock
    a_r3_lrclk_on_fall: assert property (@(posedge clk) disable iff (rst || !chk_ok)
        !$stable(lrclk) |-> $fell(bclk));

    // R3: serial output moves only with a falling bit clock
    a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (rst || !chk_ok)
        !$stable(sdo) |-> $fell(bclk));

endmodule

// File: tb/pcm_master_port_bench.sv
module pcm_master_port_bench;
    import pcm_port_pkg::*;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        lj_mode = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic [19:0] tx_left = '0, tx_right = '0;
    logic        tx_load = 1'b0;
    logic [19:0] rx_left, rx_right;
    logic        frame_done, bclk, lrclk, sdo, sdi;
    logic        tail = 1'b0;

    assign sdi = sdo | tail;

    pcm_master_port u_pcm_master_port (
        .clk(clk), .rst(rst), .lj_mode(lj_mode), .half_div(half_div),
        .tx_left(tx_left), .tx_right(tx_right), .tx_load(tx_load),
        .rx_left(rx_left), .rx_right(rx_right), .frame_done(frame_done),
        .bclk(bclk), .lrclk(lrclk), .sdo(sdo), .sdi(sdi)
    );

    typedef struct { logic [19:0] l; logic [19:0] r; } pair_t;
    pair_t tx_q[$];
    pair_t rx_q[$];
    pair_t cur = '{20'h0, 20'h0};

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic bit in_sample(int kk, bit lj);
        return lj ? (kk < 20) : (kk >= 1 && kk <= 18);
    endfunction

    function automatic int bit_pos(int kk, bit lj);
        return lj ? 19 - kk : 20 - kk;
    endfunction

    // monitor: decodes the serial link from the ports
    bit          mon_on = 1'b0, started = 1'b0, have_prev = 1'b0, dec_lj = 1'b0;
    bit          prev_b = 1'b0, prev_lr = 1'b0, ch = 1'b0;
    int          k = 0, since = 0;
    logic [19:0] got [2];

    always @(negedge clk) begin
        if (!rst && mon_on) begin
            since++;
            if (frame_done) begin
                logic [19:0] m;
                pair_t       e;
                if (have_prev)
                    check("R2 R10 frame length", since, 2 * (half_div + 1) * (dec_lj ? 128 : 64));
                if (started)
                    check("R7 right slot length", k + 1, dec_lj ? 64 : 32);
                m = dec_lj ? 20'hFFFFF : 20'hFFFFC;
                if (rx_q.size() == 0) begin
                    check("R9 rx queue underrun", 1, 0);
                end else begin
                    e = rx_q.pop_front();
                    check("R9 R8 R5 rx left", rx_left, e.l & m);
                    check("R9 R8 R5 rx right", rx_right, e.r & m);
                end
                dec_lj = lj_mode;
                check("R5 R6 left slot lrclk level", lrclk, dec_lj ? 1 : 0);
                since = 0; have_prev = 1'b1; started = 1'b1;
                k = 0; ch = 1'b0; got[0] = '0; got[1] = '0;
            end else if (prev_b && !bclk) begin
                if (lrclk !== prev_lr) begin
                    if (started) check("R7 left slot length", k + 1, dec_lj ? 64 : 32);
                    k = 0; ch = 1'b1;
                end else begin
                    k++;
                end
            end
            if (!prev_b && bclk && started) begin
                if (in_sample(k, dec_lj)) begin
                    got[ch][bit_pos(k, dec_lj)] = sdo;
                end else begin
                    check("R8 sdo zero after LSB", sdo, 0);
                end
                if (ch && k == (dec_lj ? 19 : 18)) begin
                    logic [19:0] m2;
                    pair_t       e2;
                    m2 = dec_lj ? 20'hFFFFF : 20'hFFFFC;
                    if (tx_q.size() == 0) begin
                        check("R9 tx queue underrun", 1, 0);
                    end else begin
                        e2 = tx_q.pop_front();
                        check(dec_lj ? "R6 R7 tx left" : "R5 R7 tx left", got[0], e2.l & m2);
                        check(dec_lj ? "R6 R7 tx right" : "R5 R7 tx right", got[1], e2.r & m2);
                    end
                end
            end
            prev_b  = bclk;
            prev_lr = lrclk;
            tail    = started && !in_sample(k, dec_lj);
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // driver: one call per frame, pushes the pair the next frame must carry
    task automatic do_frame(bit ld, logic [19:0] l, logic [19:0] r, bit sw, bit new_lj);
        if (ld) begin
            @(posedge clk); #1;
            tx_left = l; tx_right = r; tx_load = 1'b1;
            @(posedge clk); #1;
            tx_load = 1'b0;
            cur = '{l, r};
        end
        tx_q.push_back(cur);
        rx_q.push_back(cur);
        if (sw) begin
            repeat (60) @(posedge clk);
            #1 lj_mode = new_lj;
        end
        do begin
            @(posedge clk); #1;
        end while (!frame_done);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R11 reset bclk", bclk, 0);
        check("R11 reset lrclk", lrclk, 0);
        check("R11 reset sdo", sdo, 0);
        check("R11 reset frame_done", frame_done, 0);
        check("R11 reset rx_left", rx_left, 0);
        check("R11 reset rx_right", rx_right, 0);
        @(posedge clk); #1;
        check("R1 bclk half period", bclk, 0);
        @(posedge clk); #1;
        check("R1 bclk half period", bclk, 1);
        mon_on = 1'b1;
        rx_q.push_back('{20'h0, 20'h0});  // R11 first frame sends zeros
        do_frame(1, 20'hFFFFF, 20'h00000, 0, 0);
        do_frame(1, 20'h80001, 20'h7FFFE, 0, 0);
        do_frame(0, 20'h0, 20'h0, 0, 0);            // R9 repeat
        do_frame(1, 20'hA5A5B, 20'h35C93, 0, 0);
        do_frame(1, 20'h12345, 20'hEDCBA, 1, 1);    // R10 switch to left-justified
        do_frame(1, 20'hC0003, 20'h3FFFD, 0, 0);
        do_frame(0, 20'h0, 20'h0, 0, 0);
        do_frame(1, 20'h9E371, 20'h0F0F3, 0, 0);
        do_frame(1, 20'h55557, 20'hAAAAB, 1, 0);    // R10 switch back to I2S
        do_frame(1, 20'hFFFFF, 20'hFFFFF, 0, 0);
        do_frame(0, 20'h0, 20'h0, 0, 0);
        do begin
            @(posedge clk); #1;
        end while (!frame_done);
        @(negedge clk); #1;
        mon_on = 1'b0;
        check("R9 expected pairs drained", tx_q.size() + rx_q.size(), 0);
        summary();
        $finish;
    end

endmodule